// File: doc/BRIEF.md
# Receive Elasticity Buffer (Recovered Clock to Reference Clock)

This block moves received Ethernet data from the clock recovered off the line into the local reference clock domain of a reduced-pin receive path. Nibbles arrive with a data-valid marker on the recovered clock. They are stored in a 16-entry dual-clock FIFO whose pointers cross domains as gray codes through two-flop synchronizers. They leave on the reference clock either as 2-bit RMII symbols (50 MHz reference) or as 4-bit single-clock MII nibbles (25 MHz reference). At 10 Mb/s every output symbol is stretched over ten reference clocks.

Replay of a frame begins only once a programmable number of nibbles has collected, so latency can be traded against the frame length that survives clock drift. When the FIFO runs dry during a frame (underrun) or fills while the line is still writing (overrun), the rest of the frame is sent inverted with data-valid held high until the frame ends, so the downstream frame check fails. Sticky flags record each condition. At the end of a damaged frame the FIFO is flushed and the threshold wait starts again. The threshold and mode inputs come from a control register whose reset value for the threshold field is 01. They may only change while no frame is being replayed. Between two frames the line must stay idle for at least one recovered clock.

Write side states: W_IDLE (no frame), W_FRAME (storing nibbles), W_TERM (frame ended while full; end marker pending). Transitions: W_IDLE→W_FRAME on valid; W_FRAME→W_IDLE when valid drops and the end marker is stored; W_FRAME→W_TERM when valid drops and the FIFO is full; W_TERM→W_IDLE once the marker is stored. Read side states: R_WAIT (threshold wait), R_PLAY (clean replay), R_SPOIL (inverted replay). Transitions: R_WAIT→R_PLAY when the fill reaches the threshold; R_PLAY→R_SPOIL on underrun or on reaching data written after an overrun; R_PLAY→R_WAIT and R_SPOIL→R_WAIT at the end marker.

Top module: `rx_elastic_buf`

## Requirements
- R1: With cfg_scmii=0 each nibble leaves as two symbols on r_data[1:0], bits 1:0 first and bits 3:2 second, and r_data[3:2] is 0 whenever r_dv is 1.
- R2: With cfg_scmii=1 each nibble leaves whole on r_data[3:0], one per output slot, in the order received.
- R3: cfg_thr encodes the nibbles that must be buffered before replay starts: 00=1, 01=2, 10=3, 11=4.
- R4: With cfg_10m=1 output slots are exactly 10 reference clocks apart. r_data and r_dv change only on a slot boundary, so each symbol is held for 10 clocks.
- R5: If the FIFO is empty when a clean frame needs its next nibble, stat_udr is set, r_dv stays 1, and the remaining output of the frame is bitwise inverted (in RMII mode r_data[1:0] only).
- R6: If a nibble is lost because the FIFO is full, stat_ovr is set and the output from that point to the end of the frame is inverted, with r_dv held at 1.
- R7: stat_ovr and stat_udr stay 1 until a one-cycle clr_status pulse. A new error in the same cycle as the pulse wins.
- R8: After a damaged frame the FIFO is flushed, and the next frame is replayed intact after a fresh threshold wait.
- R9: During and right after reset r_dv, r_data, stat_ovr and stat_udr are all 0, and r_data is 0 whenever r_dv is 0.
- R10: A larger threshold tolerates more drift. With the write clock 1% slow, a 150-nibble RMII frame passes at cfg_thr=11, while a 300-nibble frame at cfg_thr=00 underruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock |
| w_rst_n | input | 1 | Active-low reset, write domain |
| w_dv | input | 1 | Received nibble valid |
| w_nib | input | 4 | Received nibble |
| rclk | input | 1 | Local reference clock |
| r_rst_n | input | 1 | Active-low reset, read domain |
| cfg_thr | input | 2 | Start threshold code |
| cfg_scmii | input | 1 | 1: 4-bit output, 0: 2-bit output |
| cfg_10m | input | 1 | 1: 10 Mb/s slot spacing |
| clr_status | input | 1 | One-cycle clear of both sticky flags |
| r_dv | output | 1 | Replayed data valid |
| r_data | output | 4 | Replayed symbol (bits 1:0 only in 2-bit mode) |
| stat_ovr | output | 1 | Sticky overrun flag |
| stat_udr | output | 1 | Sticky underrun flag |

## Verification
The hardest states to reach from the ports are underrun and overrun. At matched clock rates the FIFO level never moves far from its starting point, so neither occurs. The bench stretches or shrinks the recovered clock period by 1% to 2% against the reference clock and sends frames long enough that the accumulated slip crosses the threshold margin. The frame lengths are chosen so that the slip lands clearly on one side of the margin set by each threshold.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;

    // One FIFO slot: error mark, end-of-frame mark, data nibble.
    typedef struct packed {
        logic       err;
        logic       eof;
        logic [3:0] nib;
    } rxeb_entry_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_FRAME = 2'd1,
        W_TERM  = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        R_WAIT  = 2'd0,
        R_PLAY  = 2'd1,
        R_SPOIL = 2'd2
    } rd_state_t;

endpackage

// File: rtl/rxeb_sync.sv
module rxeb_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_out  <= '0;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/rxeb_wr.sv
module rxeb_wr
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              w_rst_n,
    input  logic              w_dv,
    input  logic [3:0]        w_nib,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output rxeb_entry_t       went,
    output logic [ADDR_W:0]   wgray
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_state_t      st, st_n;
    logic           pend, pend_n;
    logic [PW-1:0]  wbin, wbin_n, rbin_s;
    logic           full;

    assign rbin_s = g2b(rgray_s);
    assign full   = (wbin - rbin_s) == DEPTH_P;
    assign waddr  = wbin[ADDR_W-1:0];
    assign wbin_n = wbin + PW'(we);

    always_comb begin
        st_n   = st;
        pend_n = pend;
        we     = 1'b0;
        went   = '0;
        unique case (st)
            W_IDLE: begin
                if (w_dv) begin
                    st_n = W_FRAME;
                    if (full) begin
                        pend_n = 1'b1;
                    end else begin
                        we     = 1'b1;
                        went   = '{err: 1'b0, eof: 1'b0, nib: w_nib};
                        pend_n = 1'b0;
                    end
                end
            end
            W_FRAME: begin
                if (w_dv) begin
                    if (full) begin
                        pend_n = 1'b1;
                    end else begin
                        we     = 1'b1;
                        went   = '{err: pend, eof: 1'b0, nib: w_nib};
                        pend_n = 1'b0;
                    end
                end else if (full) begin
                    st_n = W_TERM;
                end else begin
                    we     = 1'b1;
                    went   = '{err: pend, eof: 1'b1, nib: 4'h0};
                    pend_n = 1'b0;
                    st_n   = W_IDLE;
                end
            end
            W_TERM: begin
                if (!full) begin
                    we     = 1'b1;
                    went   = '{err: pend, eof: 1'b1, nib: 4'h0};
                    pend_n = 1'b0;
                    st_n   = W_IDLE;
                end
            end
            default: st_n = W_IDLE;
        endcase
    end

    always_ff @(posedge wclk or negedge w_rst_n) begin
        if (!w_rst_n) begin
            st    <= W_IDLE;
            pend  <= 1'b0;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            st    <= st_n;
            pend  <= pend_n;
            wbin  <= wbin_n;
            wgray <= wbin_n ^ (wbin_n >> 1);
        end
    end
endmodule

// File: rtl/rxeb_rd.sv
module rxeb_rd
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DECIM  = 10
) (
    input  logic              rclk,
    input  logic              r_rst_n,
    input  logic [ADDR_W:0]   wgray_s,
    input  rxeb_entry_t       rentry,
    input  logic [1:0]        cfg_thr,
    input  logic              cfg_scmii,
    input  logic              cfg_10m,
    input  logic              clr_status,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              r_dv,
    output logic [3:0]        r_data,
    output logic              stat_ovr,
    output logic              stat_udr,
    output logic              slot_tick,
    output logic [ADDR_W:0]   occ
);
    localparam int PW = ADDR_W + 1;
    localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t      st, st_n;
    logic [PW-1:0]  rbin, rbin_n, wbin_s, thr_n;
    logic [CW-1:0]  dcnt;
    logic           tick, need, empty, half, half_n;
    logic [1:0]     hi, hi_n;
    logic           dv_n, ovr_set, udr_set;
    logic [3:0]     data_n, nib_v, mask;

    assign wbin_s    = g2b(wgray_s);
    assign occ       = wbin_s - rbin;
    assign empty     = (occ == '0);
    assign thr_n     = PW'(cfg_thr) + PW'(1);
    assign raddr     = rbin[ADDR_W-1:0];
    assign tick      = !cfg_10m || (dcnt == '0);
    assign slot_tick = tick && (st != R_WAIT);
    assign need      = cfg_scmii || !half;
    assign mask      = cfg_scmii ? 4'hF : 4'h3;
    assign nib_v     = rentry.nib ^ (((st == R_SPOIL) || rentry.err) ? 4'hF : 4'h0);

    always_comb begin
        st_n    = st;
        rbin_n  = rbin;
        dv_n    = r_dv;
        data_n  = r_data;
        half_n  = half;
        hi_n    = hi;
        ovr_set = 1'b0;
        udr_set = 1'b0;
        unique case (st)
            R_WAIT: begin
                half_n = 1'b0;
                if (occ >= thr_n) st_n = R_PLAY;
            end
            R_PLAY, R_SPOIL: begin
                if (tick) begin
                    if (!need) begin
                        data_n = {2'b00, hi};
                        half_n = 1'b0;
                    end else if (empty) begin
                        if (st == R_PLAY) begin
                            udr_set = 1'b1;
                            st_n    = R_SPOIL;
                            data_n  = r_data ^ mask;
                        end
                    end else begin
                        rbin_n = rbin + PW'(1);
                        if (rentry.eof) begin
                            dv_n   = 1'b0;
                            data_n = 4'h0;
                            half_n = 1'b0;
                            st_n   = R_WAIT;
                            if (rentry.err) ovr_set = 1'b1;
                            if (rentry.err || (st == R_SPOIL)) rbin_n = wbin_s;
                        end else begin
                            dv_n = 1'b1;
                            if (rentry.err) begin
                                ovr_set = 1'b1;
                                st_n    = R_SPOIL;
                            end
                            if (cfg_scmii) begin
                                data_n = nib_v;
                            end else begin
                                data_n = {2'b00, nib_v[1:0]};
                                hi_n   = nib_v[3:2];
                                half_n = 1'b1;
                            end
                        end
                    end
                end
            end
            default: st_n = R_WAIT;
        endcase
    end

    always_ff @(posedge rclk or negedge r_rst_n) begin
        if (!r_rst_n) begin
            st     <= R_WAIT;
            rbin   <= '0;
            rgray  <= '0;
            r_dv   <= 1'b0;
            r_data <= 4'h0;
            half   <= 1'b0;
            hi     <= 2'b00;
        end else begin
            st     <= st_n;
            rbin   <= rbin_n;
            rgray  <= rbin_n ^ (rbin_n >> 1);
            r_dv   <= dv_n;
            r_data <= data_n;
            half   <= half_n;
            hi     <= hi_n;
        end
    end

    always_ff @(posedge rclk or negedge r_rst_n) begin
        if (!r_rst_n) begin
            dcnt <= '0;
        end else if (st == R_WAIT) begin
            dcnt <= '0;
        end else if (cfg_10m) begin
            dcnt <= (dcnt == CW'(DECIM - 1)) ? '0 : dcnt + CW'(1);
        end
    end

    always_ff @(posedge rclk or negedge r_rst_n) begin
        if (!r_rst_n) begin
            stat_ovr <= 1'b0;
            stat_udr <= 1'b0;
        end else begin
            if (ovr_set)         stat_ovr <= 1'b1;
            else if (clr_status) stat_ovr <= 1'b0;
            if (udr_set)         stat_udr <= 1'b1;
            else if (clr_status) stat_udr <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import rxeb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DECIM  = 10
) (
    input  logic       wclk,
    input  logic       w_rst_n,
    input  logic       w_dv,
    input  logic [3:0] w_nib,
    input  logic       rclk,
    input  logic       r_rst_n,
    input  logic [1:0] cfg_thr,
    input  logic       cfg_scmii,
    input  logic       cfg_10m,
    input  logic       clr_status,
    output logic       r_dv,
    output logic [3:0] r_data,
    output logic       stat_ovr,
    output logic       stat_udr
);
    localparam int DEPTH = 1 << ADDR_W;

    rxeb_entry_t       mem [DEPTH];
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    rxeb_entry_t       went;
    logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;
    logic              rd_tick;
    logic [ADDR_W:0]   rd_occ;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= went;
    end

    rxeb_sync #(.WIDTH(ADDR_W + 1)) u_sync_r2w (
        .clk(wclk), .rst_n(w_rst_n), .d_in(rgray), .d_out(rgray_s)
    );

    rxeb_sync #(.WIDTH(ADDR_W + 1)) u_sync_w2r (
        .clk(rclk), .rst_n(r_rst_n), .d_in(wgray), .d_out(wgray_s)
    );

    rxeb_wr #(.ADDR_W(ADDR_W)) u_wr (
        .wclk(wclk), .w_rst_n(w_rst_n), .w_dv(w_dv), .w_nib(w_nib),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .went(went), .wgray(wgray)
    );

    rxeb_rd #(.ADDR_W(ADDR_W), .DECIM(DECIM)) u_rd (
        .rclk(rclk), .r_rst_n(r_rst_n), .wgray_s(wgray_s), .rentry(mem[raddr]),
        .cfg_thr(cfg_thr), .cfg_scmii(cfg_scmii), .cfg_10m(cfg_10m),
        .clr_status(clr_status), .raddr(raddr), .rgray(rgray),
        .r_dv(r_dv), .r_data(r_data), .stat_ovr(stat_ovr), .stat_udr(stat_udr),
        .slot_tick(rd_tick), .occ(rd_occ)
    );
endmodule

// File: rtl/rx_elastic_buf_chk.sv
module rx_elastic_buf_chk #(
    parameter int ADDR_W = 4
) (
    input logic            rclk,
    input logic            r_rst_n,
    input logic            cfg_scmii,
    input logic            cfg_10m,
    input logic            clr_status,
    input logic            r_dv,
    input logic [3:0]      r_data,
    input logic            stat_ovr,
    input logic            stat_udr,
    input logic            rd_tick,
    input logic [ADDR_W:0] rd_occ
);
    localparam logic [ADDR_W:0] DEPTH_P = (ADDR_W + 1)'(1 << ADDR_W);

    p_rmii_upper_zero_r1: assert property (@(posedge rclk) disable iff (!r_rst_n)
        (r_dv && !cfg_scmii) |-> (r_data[3:2] == 2'b00));

    p_hold_between_slots_r4: assert property (@(posedge rclk) disable iff (!r_rst_n)
        !$past(rd_tick) |-> ($stable(r_data) && $stable(r_dv)));

    p_slot_spacing_r4: assert property (@(posedge rclk) disable iff (!r_rst_n)
        (cfg_10m && rd_tick) |=> !rd_tick);

    p_udr_in_frame_r5: assert property (@(posedge rclk) disable iff (!r_rst_n)
        $rose(stat_udr) |-> r_dv);

    p_occ_bound_r6: assert property (@(posedge rclk) disable iff (!r_rst_n)
        rd_occ <= DEPTH_P);

    p_ovr_sticky_r7: assert property (@(posedge rclk) disable iff (!r_rst_n)
        (stat_ovr && !clr_status) |=> stat_ovr);

    p_udr_sticky_r7: assert property (@(posedge rclk) disable iff (!r_rst_n)
        (stat_udr && !clr_status) |=> stat_udr);

    p_idle_quiet_r9: assert property (@(posedge rclk) disable iff (!r_rst_n)
        !r_dv |-> (r_data == 4'h0));
endmodule

bind rx_elastic_buf rx_elastic_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .rclk(rclk), .r_rst_n(r_rst_n), .cfg_scmii(cfg_scmii), .cfg_10m(cfg_10m),
    .clr_status(clr_status), .r_dv(r_dv), .r_data(r_data), .stat_ovr(stat_ovr),
    .stat_udr(stat_udr), .rd_tick(rd_tick), .rd_occ(rd_occ)
);

// File: tb/rx_elastic_buf_tb.sv
`timescale 1ps/1ps
module rx_elastic_buf_tb;
    logic rclk = 1'b0, wclk = 1'b0;
    int   wper = 8000;
    always #2000 rclk = ~rclk;
    always begin
        #(wper / 2);
        wclk = ~wclk;
    end

    logic       w_rst_n, r_rst_n, w_dv, cfg_scmii, cfg_10m, clr_status;
    logic [3:0] w_nib, r_data;
    logic [1:0] cfg_thr;
    logic       r_dv, stat_ovr, stat_udr;

    rx_elastic_buf u_dut (
        .wclk(wclk), .w_rst_n(w_rst_n), .w_dv(w_dv), .w_nib(w_nib),
        .rclk(rclk), .r_rst_n(r_rst_n), .cfg_thr(cfg_thr), .cfg_scmii(cfg_scmii),
        .cfg_10m(cfg_10m), .clr_status(clr_status), .r_dv(r_dv), .r_data(r_data),
        .stat_ovr(stat_ovr), .stat_udr(stat_udr)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [3:0] sent[$], got[$], capq[$];
    bit    cap_en = 0, prev_dv = 0, upper_ok = 1;
    int    rises = 0;
    longint t_in = 0, t_out = 0;

    always @(negedge rclk) begin
        if (cap_en) begin
            if (r_dv) begin
                capq.push_back(r_data);
                if (!cfg_scmii && r_data[3:2] != 2'b00) upper_ok = 0;
                if (!prev_dv) begin
                    rises++;
                    if (rises == 1) t_out = $time;
                end
            end
            prev_dv = r_dv;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int i, input int seed);
        return 4'((i * 5 + seed + (i >> 3)) & 15);
    endfunction

    task automatic send_frame(input int len, input int seed);
        sent.delete();
        @(negedge wclk);
        for (int i = 0; i < len; i++) begin
            w_dv  = 1'b1;
            w_nib = pat(i, seed);
            sent.push_back(w_nib);
            @(posedge wclk);
            if (i == 0) t_in = $time;
            @(negedge wclk);
        end
        w_dv  = 1'b0;
        w_nib = 4'h0;
    endtask

    task automatic run_frame(input int len, input int seed);
        int quiet;
        capq.delete();
        rises = 0; prev_dv = 0; upper_ok = 1; cap_en = 1;
        send_frame(len, seed);
        quiet = 0;
        for (int g = 0; g < 40000 && quiet < 80; g++) begin
            @(negedge rclk);
            quiet = r_dv ? 0 : quiet + 1;
        end
        cap_en = 0;
    endtask

    task automatic decode(output bit hold_ok);
        logic [3:0] slots[$];
        hold_ok = 1;
        got.delete();
        if (cfg_10m) begin
            for (int i = 0; i < capq.size(); i++) begin
                if (i % 10 == 0) slots.push_back(capq[i]);
                else if (capq[i] != capq[i-1]) hold_ok = 0;
            end
            if (capq.size() % 10 != 0) hold_ok = 0;
        end else begin
            slots = capq;
        end
        if (cfg_scmii) got = slots;
        else for (int i = 0; i + 1 < slots.size(); i += 2)
            got.push_back({slots[i+1][1:0], slots[i][1:0]});
    endtask

    function automatic int mismatches();
        int m = (got.size() > sent.size()) ? got.size() - sent.size()
                                           : sent.size() - got.size();
        for (int i = 0; i < got.size() && i < sent.size(); i++)
            if (got[i] != sent[i]) m++;
        return m;
    endfunction

    task automatic set_mode(input bit sc, input bit m10, input logic [1:0] thr, input int wp);
        @(negedge rclk);
        cfg_scmii = sc; cfg_10m = m10; cfg_thr = thr; wper = wp;
        repeat (4) @(negedge rclk);
    endtask

    task automatic pulse_clear();
        @(negedge rclk); clr_status = 1'b1;
        @(negedge rclk); clr_status = 1'b0;
        @(negedge rclk);
    endtask

    task automatic clean_frame(input string req, input int len, input int seed);
        bit h;
        run_frame(len, seed);
        decode(h);
        chk(mismatches() == 0, req, "data mismatches", mismatches(), 0);
        chk(rises == 1, req, "valid rises", rises, 1);
    endtask

    task automatic t_reset();
        w_rst_n = 0; r_rst_n = 0; w_dv = 0; w_nib = 0; clr_status = 0;
        cfg_scmii = 0; cfg_10m = 0; cfg_thr = 2'b01;
        repeat (5) @(negedge rclk);
        chk(r_dv == 0 && r_data == 0, "R9", "outputs in reset", {r_dv, r_data}, 0);
        w_rst_n = 1; r_rst_n = 1;
        repeat (3) @(negedge rclk);
        chk({r_dv, r_data, stat_ovr, stat_udr} == 0, "R9", "after reset",
            {r_dv, r_data, stat_ovr, stat_udr}, 0);
    endtask

    task automatic t_rmii();
        set_mode(0, 0, 2'b01, 8000);
        clean_frame("R1", 24, 3);
        chk(upper_ok, "R1", "upper bits zero", upper_ok, 1);
        clean_frame("R1", 7, 9);
        chk(stat_ovr == 0 && stat_udr == 0, "R1", "no flags", {stat_ovr, stat_udr}, 0);
    endtask

    task automatic t_scmii();
        set_mode(1, 0, 2'b01, 4000);
        clean_frame("R2", 30, 5);
        clean_frame("R2", 1, 11);
        chk(stat_ovr == 0 && stat_udr == 0, "R2", "no flags", {stat_ovr, stat_udr}, 0);
    endtask

    task automatic t_tenmeg();
        bit h;
        set_mode(0, 1, 2'b01, 80000);
        run_frame(6, 2); decode(h);
        chk(h, "R4", "rmii 10-clock hold", h, 1);
        chk(mismatches() == 0, "R4", "rmii data", mismatches(), 0);
        set_mode(1, 1, 2'b01, 40000);
        run_frame(6, 7); decode(h);
        chk(h, "R4", "scmii 10-clock hold", h, 1);
        chk(mismatches() == 0, "R4", "scmii data", mismatches(), 0);
    endtask

    task automatic t_thresh();
        bit h;
        for (int k = 0; k < 4; k++) begin
            longint lat, lo, hi;
            set_mode(0, 1, 2'(k), 80000);
            run_frame(8, k);
            decode(h);
            lat = t_out - t_in;
            lo  = longint'(k) * 80000 + 12000;
            hi  = longint'(k) * 80000 + 28000;
            chk(lat >= lo && lat <= hi, "R3", "start latency ps", lat, lo);
            chk(mismatches() == 0, "R3", "data", mismatches(), 0);
        end
    endtask

    task automatic t_underrun();
        bit h;
        set_mode(0, 0, 2'b11, 8080);
        run_frame(600, 4); decode(h);
        chk(stat_udr == 1, "R5", "underrun flag", stat_udr, 1);
        chk(mismatches() != 0, "R5", "frame corrupted", mismatches(), 1);
        chk(rises == 1, "R5", "valid held through frame", rises, 1);
        set_mode(0, 0, 2'b01, 8000);
        clean_frame("R8", 20, 6);
        chk(stat_udr == 1, "R7", "underrun flag sticky", stat_udr, 1);
        pulse_clear();
        chk(stat_udr == 0, "R7", "underrun flag cleared", stat_udr, 0);
    endtask

    task automatic t_overrun();
        bit h;
        set_mode(0, 0, 2'b01, 7840);
        run_frame(1000, 8); decode(h);
        chk(stat_ovr == 1, "R6", "overrun flag", stat_ovr, 1);
        chk(mismatches() != 0, "R6", "frame corrupted", mismatches(), 1);
        chk(rises == 1, "R6", "valid held through frame", rises, 1);
        set_mode(0, 0, 2'b01, 8000);
        clean_frame("R8", 20, 1);
        chk(stat_ovr == 1, "R7", "overrun flag sticky", stat_ovr, 1);
        pulse_clear();
        chk(stat_ovr == 0, "R7", "overrun flag cleared", stat_ovr, 0);
    endtask

    task automatic t_drift();
        set_mode(0, 0, 2'b11, 8080);
        clean_frame("R10", 150, 12);
        chk(stat_udr == 0, "R10", "thr 11 tolerates slip", stat_udr, 0);
        set_mode(0, 0, 2'b00, 8080);
        run_frame(300, 13);
        chk(stat_udr == 1, "R10", "thr 00 underruns", stat_udr, 1);
        pulse_clear();
    endtask

    initial begin
        #(longint'(190000) * 4000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rmii();
        t_scmii();
        t_tenmeg();
        t_thresh();
        t_underrun();
        t_overrun();
        t_drift();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule